// File: doc/BRIEF.md
# Laser Transmitter Safety Controller

This block is the digital control and status logic for a multi-lane optical transmitter. It takes an active-high enable, an active-high disable, an active-low module clear and one fault flag per lane. It drives one laser-enable bit per lane and an active-low fault status. The analog driver, bias loop and fault sensing sit outside the block and report to it through plain digital inputs.

The lanes turn on only when enable is high and disable is low, and only after two delays. The first is a settling interval that follows power-up or a clear. The second is an arming interval that follows the request to turn on. A fault on any single lane latches a global shutdown and drives the status output low. Only a clear pulse that is held long enough removes the latch. The clear also fails if the fault is still present when it is released. All intervals are cycle counts derived from a clock-frequency parameter. A simulation divider shortens the two long delays.

Top module: `laser_safety_ctrl`

## Requirements
- R1: Lanes are on only while synchronised enable is 1 and disable is 0. The combinations 00, 10 and 11 (enable, disable) keep every lane off.
- R2: When any lane fault input goes to 1, every lane turns off and `fault_n_o` goes to 0 by the third clock edge after the input change.
- R3: The fault latch survives fault removal and any clear pulse shorter than CLR_CYC cycles (10 µs of clock). It is cleared only when `clr_n_i` returns to 1 after staying at 0 for at least CLR_CYC cycles.
- R4: All lane-enable bits always carry the same value.
- R5: After a qualifying clear with no fault present, `fault_n_o` is 1 and the lanes stay off for at least SETTLE_CYC cycles (100 ms of clock divided by SIM_DIV).
- R6: From the ready-but-off state, a move into the operating combination turns the lanes on after more than ENABLE_CYC cycles and no later than ENABLE_CYC+4 edges (ENABLE_CYC is 1 ms of clock divided by SIM_DIV).
- R7: Dropping enable or raising disable turns every lane off by the third clock edge.
- R8: If a clear is released while a lane fault is still 1, `fault_n_o` stays 0, the lanes stay off, and the settling interval does not start.
- R9: During and after system reset `rst_n`, the lanes are off and `fault_n_o` is 1. The settling interval of R5 runs before any lane can turn on.
- R10: In any non-fault state, driving `clr_n_i` low turns the lanes off within three edges and restarts the settling interval, whatever the length of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_HZ |
| rst_n | input | 1 | Synchronous active-low system reset |
| tx_on_i | input | 1 | Asynchronous enable request, active high |
| tx_off_i | input | 1 | Asynchronous disable request, active high |
| clr_n_i | input | 1 | Asynchronous module clear, active low |
| lane_fault_i | input | LANES | Per-lane laser fault flags from the analog side |
| lane_en_o | output | LANES | Per-lane laser enable |
| fault_n_o | output | 1 | Latched fault status, 0 = fault |

## Verification
A state register stuck in run or a latch that fails to hold shows at the ports within three edges of a fault or a drop in enable. In that case some lane bit stays 1 or `fault_n_o` returns high with the fault flag still set. A wrong timer load or a miscounted clear qualification shows up differently. The lanes come on early or late against the settling and arming windows, or a short clear pulse removes the latch. The bench samples these windows close to their bounds.

// File: rtl/lsc_pkg.sv
// Package: shared state encoding for the laser safety controller.
// Assumes: nothing beyond a SystemVerilog compiler.
package lsc_pkg;
    typedef enum logic [2:0] {
        ST_SETTLE = 3'd0,   // not ready, settling timer running
        ST_IDLE   = 3'd1,   // ready, lanes off by request
        ST_ARMING = 3'd2,   // turn-on requested, arming timer running
        ST_RUN    = 3'd3,   // lanes on
        ST_FAULT  = 3'd4    // latched fault, lanes off
    } lsc_state_e;
endpackage

// File: rtl/lsc_sync.sv
// Module: two-flop synchroniser bank, one chain per bit.
// Assumes: inputs are asynchronous levels; RST_VAL is the safe level.
module lsc_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, sync_q;
        // Purpose: two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                sync_q <= RST_VAL;
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end
        assign q_o[g] = sync_q;
    end
endmodule

// File: rtl/lsc_timer.sv
// Module: loadable down counter; done is high while the count is zero.
// Assumes: load has priority; after reset the count starts at INIT.
module lsc_timer #(
    parameter int W    = 8,
    parameter int INIT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    // Purpose: load or count down toward zero, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= W'(INIT);
        else if (load_i)       cnt_q <= load_val_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lsc_clr_qual.sv
// Module: qualifies the module clear; flags a release after a long enough low.
// Assumes: clr_n_s is already synchronised; HOLD_CYC >= 1.
module lsc_clr_qual #(
    parameter int HOLD_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_s,
    output logic held_low_o,
    output logic release_ok_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] low_cnt_q;
    logic          lvl_q;

    // Purpose: count low cycles (saturating) and remember last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            lvl_q     <= 1'b1;
        end else begin
            lvl_q <= clr_n_s;
            if (clr_n_s)                        low_cnt_q <= '0;
            else if (low_cnt_q != CW'(HOLD_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign held_low_o   = !clr_n_s;
    assign release_ok_o = clr_n_s && !lvl_q && (low_cnt_q == CW'(HOLD_CYC));

    // R3: a qualified release only follows a low level
    a_r3_release_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        release_ok_o |-> $past(!clr_n_s));
endmodule

// File: rtl/laser_safety_ctrl.sv
// Module: laser transmitter safety controller (top).
// Does: synchronises controls and faults, sequences settle/arm delays,
//       latches any lane fault into a global shutdown.
// Assumes: CLK_HZ is the clk frequency; SIM_DIV only shortens long delays.
module laser_safety_ctrl
    import lsc_pkg::*;
#(
    parameter int LANES   = 12,
    parameter int CLK_HZ  = 50_000_000,
    parameter int SIM_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_on_i,
    input  logic             tx_off_i,
    input  logic             clr_n_i,
    input  logic [LANES-1:0] lane_fault_i,
    output logic [LANES-1:0] lane_en_o,
    output logic             fault_n_o
);
    localparam int SETTLE_CYC = (CLK_HZ / 10) / SIM_DIV;
    localparam int ENABLE_CYC = (CLK_HZ / 1000) / SIM_DIV;
    localparam int CLR_CYC    = CLK_HZ / 100_000;
    localparam int MAX_CYC    = (SETTLE_CYC > ENABLE_CYC) ? SETTLE_CYC : ENABLE_CYC;
    localparam int TW         = $clog2(MAX_CYC + 1);

    logic [1:0]       ctl_s;
    logic             clr_n_s;
    logic [LANES-1:0] flt_s;
    logic             go, any_flt, clr_low, clr_ok, tmr_done, tmr_load;
    logic [TW-1:0]    tmr_val;
    lsc_state_e       st_q, st_d;

    lsc_sync #(.W(2), .RST_VAL(1'b0)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d_i({tx_off_i, tx_on_i}), .q_o(ctl_s));
    lsc_sync #(.W(1), .RST_VAL(1'b1)) u_clr_sync (
        .clk(clk), .rst_n(rst_n), .d_i(clr_n_i), .q_o(clr_n_s));
    lsc_sync #(.W(LANES), .RST_VAL(1'b0)) u_flt_sync (
        .clk(clk), .rst_n(rst_n), .d_i(lane_fault_i), .q_o(flt_s));

    lsc_clr_qual #(.HOLD_CYC(CLR_CYC)) u_clr_qual (
        .clk(clk), .rst_n(rst_n), .clr_n_s(clr_n_s),
        .held_low_o(clr_low), .release_ok_o(clr_ok));

    lsc_timer #(.W(TW), .INIT(SETTLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .load_val_i(tmr_val), .done_o(tmr_done));

    assign go      = ctl_s[0] && !ctl_s[1];
    assign any_flt = |flt_s;

    // Purpose: next-state and timer-load decision; faults take priority.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = TW'(SETTLE_CYC);
        if (any_flt) begin
            st_d = ST_FAULT;
        end else if (st_q == ST_FAULT) begin
            if (clr_ok) begin
                st_d     = ST_SETTLE;
                tmr_load = 1'b1;
            end
        end else if (clr_low) begin
            st_d     = ST_SETTLE;
            tmr_load = 1'b1;
        end else begin
            case (st_q)
                ST_SETTLE: if (tmr_done) st_d = ST_IDLE;
                ST_IDLE: begin
                    if (go) begin
                        st_d     = ST_ARMING;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(ENABLE_CYC);
                    end
                end
                ST_ARMING: begin
                    if (!go)           st_d = ST_IDLE;
                    else if (tmr_done) st_d = ST_RUN;
                end
                ST_RUN:  if (!go) st_d = ST_IDLE;
                default: begin
                    st_d     = ST_SETTLE;
                    tmr_load = 1'b1;
                end
            endcase
        end
    end

    // Purpose: state register; power-on state is settling, lanes off.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_SETTLE;
        else        st_q <= st_d;
    end

    assign lane_en_o = {LANES{st_q == ST_RUN}};
    assign fault_n_o = (st_q != ST_FAULT);

    // R1: lanes on only when the previous synchronised controls allowed it
    a_r1_on_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_en_o) |-> $past(go));
    // R2: any synchronised lane fault shuts all lanes and flags the fault
    a_r2_fault_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        any_flt |=> (lane_en_o == '0) && !fault_n_o);
    // R3: without a clear edge the latch holds
    a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n_o && clr_n_s && $past(clr_n_s)) |=> !fault_n_o);
    // R4: all lanes share one value
    a_r4_lanes_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_en_o == '0) || (&lane_en_o));
    // R6: lanes switch on only once a timer has expired
    a_r6_on_after_timer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_en_o[0]) |-> $past(tmr_done));
    // R8: a fault still present keeps the latch set
    a_r8_fault_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n_o && any_flt) |=> !fault_n_o);
endmodule

// File: tb/test_laser_safety_ctrl.sv
module test_laser_safety_ctrl;
    localparam int LANES   = 12;
    localparam int CLK_HZ  = 50_000_000;
    localparam int SIM_DIV = 1000;
    localparam int SETTLE  = (CLK_HZ / 10) / SIM_DIV;
    localparam int ENABLE  = (CLK_HZ / 1000) / SIM_DIV;
    localparam int CLRC    = CLK_HZ / 100_000;

    logic clk = 1'b0;
    logic rst_n, tx_on, tx_off, clr_n;
    logic [LANES-1:0] flt;
    logic [LANES-1:0] lane_en;
    logic fault_n;
    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    laser_safety_ctrl #(.LANES(LANES), .CLK_HZ(CLK_HZ), .SIM_DIV(SIM_DIV)) i_laser_safety_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_on_i(tx_on), .tx_off_i(tx_off),
        .clr_n_i(clr_n), .lane_fault_i(flt), .lane_en_o(lane_en), .fault_n_o(fault_n));

    function automatic logic [LANES-1:0] exp_en(input logic on, input logic off, input bit faulted);
        return (on && !off && !faulted) ? {LANES{1'b1}} : '0;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [LANES-1:0] e_en, input logic e_fn);
        n_vec++;
        if (lane_en !== e_en || fault_n !== e_fn) begin
            n_bad++;
            $display("FAIL %s: lane_en=%h fault_n=%b expected lane_en=%h fault_n=%b",
                     req, lane_en, fault_n, e_en, e_fn);
        end
    endtask

    task automatic clear_pulse(input int len);
        clr_n = 1'b0;
        wait_n(len);
        clr_n = 1'b1;
    endtask

    initial begin
        #(20ns * 190_000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit faulted;
        void'($urandom(32'd4242));
        rst_n = 1'b0; tx_on = 1'b0; tx_off = 1'b0; clr_n = 1'b1; flt = '0;
        wait_n(5);
        check("R9 reset state", '0, 1'b1);
        tx_on = 1'b1;
        @(negedge clk) rst_n = 1'b1;
        wait_n(SETTLE - 2);
        check("R9 settle after power-up", '0, 1'b1);
        wait_n(ENABLE + 20);
        check("R5 on after settle and arm", exp_en(1, 0, 0), 1'b1);

        // R7 and R1: leaving the operating combination
        tx_off = 1'b1;
        wait_n(4);
        check("R7 disable rises", '0, 1'b1);
        wait_n(ENABLE + 10);
        check("R1 on=1 off=1", '0, 1'b1);
        tx_on = 1'b0;
        wait_n(ENABLE + 10);
        check("R1 on=0 off=1", '0, 1'b1);
        tx_off = 1'b0;
        wait_n(ENABLE + 10);
        check("R1 on=0 off=0", '0, 1'b1);

        // R6: arming delay window
        tx_on = 1'b1;
        wait_n(ENABLE);
        check("R6 not before arming delay", '0, 1'b1);
        wait_n(5);
        check("R6 on within arming bound", {LANES{1'b1}}, 1'b1);
        tx_on = 1'b0;
        wait_n(4);
        check("R7 enable falls", '0, 1'b1);
        tx_on = 1'b1;
        wait_n(ENABLE + 10);

        // R10: short clear in run state
        clear_pulse(3);
        wait_n(2);
        check("R10 clear forces off", '0, 1'b1);
        wait_n(SETTLE - 10);
        check("R10 settle restarted", '0, 1'b1);
        wait_n(ENABLE + 20);
        check("R5 on after restart", {LANES{1'b1}}, 1'b1);

        // R2: one-lane fault pulse
        flt[7] = 1'b1;
        wait_n(2);
        flt = '0;
        wait_n(2);
        check("R2 one lane faults all off", '0, 1'b0);
        wait_n(ENABLE + 50);
        check("R3 latched after fault removal", '0, 1'b0);

        // R3: short clear ignored
        clear_pulse(CLRC / 2);
        wait_n(10);
        check("R3 short clear ignored", '0, 1'b0);

        // R8: release while fault present
        flt[0] = 1'b1;
        clear_pulse(CLRC + 10);
        wait_n(10);
        check("R8 release with fault present", '0, 1'b0);
        flt = '0;
        wait_n(SETTLE + ENABLE + 20);
        check("R8 timer not started", '0, 1'b0);

        // R5: qualifying clear with no fault
        clear_pulse(CLRC + 10);
        wait_n(10);
        check("R5 fault cleared, not ready", '0, 1'b1);
        wait_n(SETTLE - 15);
        check("R5 still settling", '0, 1'b1);
        wait_n(ENABLE + 25);
        check("R5 running after settle", {LANES{1'b1}}, 1'b1);

        // Random mix of controls and faults
        faulted = 1'b0;
        for (int it = 0; it < 40; it++) begin
            if ($urandom_range(0, 7) == 0) begin
                int lane = $urandom_range(0, LANES - 1);
                flt[lane] = 1'b1;
                wait_n(3);
                flt = '0;
                wait_n(2);
                check("R2 random lane fault", '0, 1'b0);
                clear_pulse(CLRC + $urandom_range(0, 20));
                tx_on  = 1'($urandom_range(0, 1));
                tx_off = 1'($urandom_range(0, 1));
                wait_n(SETTLE + ENABLE + 20);
                check("R5 random recovery", exp_en(tx_on, tx_off, faulted), 1'b1);
            end else begin
                tx_on  = 1'($urandom_range(0, 3) != 0);
                tx_off = 1'($urandom_range(0, 3) == 0);
                wait_n(ENABLE + 10);
                check("R1 random controls", exp_en(tx_on, tx_off, faulted), 1'b1);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule